// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial slave port that lets a host read and write a bank of 8-bit configuration registers. The host lowers the active-low select, then shifts in an instruction byte that carries the transfer direction, a byte count and the first register address. One to four data bytes follow. In a burst, each later byte goes to the register one address below the previous one. All register contents are also driven on a flat parallel bus, so the surrounding logic can use them directly.

A static mode input chooses between two wiring options. In 3-wire mode, one shared data line carries both directions. It is presented here as split pad signals (input, output, output enable) that a pad cell joins together. In 4-wire mode, a dedicated input pin and a dedicated output pin are used.

The serial pins are oversampled by the block's own clock through a short synchronizer. The serial clock must therefore run well below the system clock. Each serial clock phase must last at least `SYNC_STAGES + 2` system clock cycles.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset every register reads 8'h00, `sdo` is 0 and `sdio_oe` is 0.
- R2: The first byte after `cs_n` falls is the instruction, sent MSB first. Bit 7 selects the direction (0 = write, 1 = read). Bits 6:5 hold N, and N+1 data bytes follow. Bits 4:0 give the first register address.
- R3: Input bits are sampled on rising `sclk` edges, MSB first. A write byte is stored in its register only once all 8 bits have arrived.
- R4: After each data byte the address steps down by one, and exactly N+1 registers are accessed in one transaction.
- R5: When the address steps down from 0, it wraps to 31.
- R6: Read data is launched on falling `sclk` edges, MSB first. Each bit is valid at the following rising edge. The first bit comes after the falling edge that follows the instruction byte.
- R7: In 3-wire mode, input comes from `sdio_i` and read data goes to `sdio_o`. `sdio_oe` is 1 only during the data phase of a read. It is 0 during the instruction byte, during writes and while `cs_n` is high.
- R8: In 4-wire mode, input comes from `sdi` and read data goes to `sdo`. `sdio_i` is ignored and `sdio_oe` stays 0. In 3-wire mode, `sdi` is ignored.
- R9: If `cs_n` rises before a byte is complete, the partial byte is discarded and no register changes. The next transaction starts again with an instruction byte.
- R10: Once N+1 data bytes have been transferred, further `sclk` pulses are ignored until `cs_n` goes high.
- R11: `regs_flat[8*i +: 8]` always equals register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | 1 = shared data line, 0 = separate in/out pins |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in (4-wire mode) |
| sdio_i | input | 1 | Shared line, input side (3-wire mode) |
| sdio_o | output | 1 | Shared line, output side (3-wire mode) |
| sdio_oe | output | 1 | Output enable for the shared line |
| sdo | output | 1 | Serial data out (4-wire mode) |
| regs_flat | output | 256 | All registers; register i at bits 8*i+7 to 8*i |

## Verification
A wrong bit counter or a wrong address is not visible on the parallel bus until a byte finishes. It then shows as one wrong register, or as a register that was written when it should not have been. A stale direction flag or phase state shows sooner, within one `sclk` half-period. In that case `sdio_oe` rises during a write, or serial output appears on the wrong pin. The bench keeps its own model of the register bank and reads every burst back in the other wire mode. An error in address stepping or in the wrap from 0 to 31 therefore appears as a wrong byte in the next read of the same registers.

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            three_wire,
  input  logic                            cs_n,
  input  logic                            sclk,
  input  logic                            sdi,
  input  logic                            sdio_i,
  output logic                            sdio_o,
  output logic                            sdio_oe,
  output logic                            sdo,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   regs_flat
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

  typedef enum logic [1:0] {ST_INSTR, ST_DATA, ST_DONE} st_t;

  logic [SYNC_STAGES-1:0] sclk_p, cs_p, din_p;
  logic                   sclk_d;
  st_t                    st_q;
  logic [DATA_W-2:0]      shift_q;
  logic [BIT_W-1:0]       bit_q;
  logic [CNT_W-1:0]       left_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   rw_q, sdo_q, oe_q;
  logic [DATA_W-1:0]      regs_q [NREG];

  wire sclk_s   = sclk_p[SYNC_STAGES-1];
  wire cs_s     = cs_p[SYNC_STAGES-1];
  wire din_s    = din_p[SYNC_STAGES-1];
  wire rise     = sclk_s & ~sclk_d & ~cs_s;
  wire fall     = ~sclk_s & sclk_d & ~cs_s;
  wire last_bit = (bit_q == LAST);
  wire [DATA_W-1:0] byte_in = {shift_q, din_s};
  wire [BIT_W-1:0]  rd_idx  = LAST - bit_q;

  assign sdio_o  = sdo_q;
  assign sdio_oe = oe_q & three_wire;
  assign sdo     = three_wire ? 1'b0 : sdo_q;

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= '0;
      cs_p    <= '1;
      din_p   <= '0;
      sclk_d  <= 1'b0;
      st_q    <= ST_INSTR;
      shift_q <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= RST_VAL;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      din_p  <= {din_p[SYNC_STAGES-2:0], three_wire ? sdio_i : sdi};
      sclk_d <= sclk_s;
      if (cs_s) begin
        st_q  <= ST_INSTR;
        bit_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        if (rise && st_q != ST_DONE) begin
          shift_q <= byte_in[DATA_W-2:0];
          bit_q   <= last_bit ? '0 : bit_q + 1'b1;
          if (last_bit) begin
            if (st_q == ST_INSTR) begin
              rw_q   <= byte_in[DATA_W-1];
              left_q <= byte_in[ADDR_W +: CNT_W];
              addr_q <= byte_in[ADDR_W-1:0];
              st_q   <= ST_DATA;
            end else begin
              if (!rw_q) regs_q[addr_q] <= byte_in;
              addr_q <= addr_q - 1'b1;
              if (left_q == '0) begin
                st_q <= ST_DONE;
                oe_q <= 1'b0;
              end else begin
                left_q <= left_q - 1'b1;
              end
            end
          end
        end
        if (fall && st_q == ST_DATA && rw_q) begin
          sdo_q <= regs_q[addr_q][rd_idx];
          oe_q  <= 1'b1;
        end
      end
    end
  end

  assert_oe_read_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (st_q == ST_DATA && rw_q && !cs_s));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_q == '0 && st_q == ST_INSTR && !oe_q));

  assert_done_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> $stable(regs_flat));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && st_q == ST_DATA && last_bit) |=> (addr_q == ADDR_W'($past(addr_q) - 1'b1)));

  assert_one_byte_per_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(regs_flat ^ $past(regs_flat)) <= DATA_W);
endmodule

// File: tb/cfg_spi_slave_bench.sv
module cfg_spi_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic three_wire = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo;
  logic [255:0] regs_flat;
  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [32];

  always #2.5 clk = ~clk;

  cfg_spi_slave u_cfg_spi_slave (
    .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo),
    .regs_flat(regs_flat));

  // {mode (1 = 3-wire), instruction, first..fourth data byte}
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 8'h65, 32'hA53C0FF0},
    {1'b0, 8'hE5, 32'h00000000},
    {1'b0, 8'h20, 32'h817E0000},
    {1'b1, 8'hA0, 32'h00000000},
    {1'b1, 8'h11, 32'hC3000000},
    {1'b0, 8'hD1, 32'h00000000},
    {1'b0, 8'h5F, 32'h11223300},
    {1'b1, 8'hFF, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r, output logic o);
    if (three_wire) begin sdio_i = b; sdi = ~b; end
    else begin sdi = b; sdio_i = ~b; end
    repeat (4) @(negedge clk);
    r = three_wire ? sdio_o : sdo;
    o = sdio_oe;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic m, input logic [7:0] ins, input int nb, input logic [31:0] wd,
                      output logic [31:0] rd, output logic oe_i, output logic oe_d);
    logic r, o;
    rd = '0; oe_i = 1'b0; oe_d = 1'b1;
    three_wire = m; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin sbit(ins[i], r, o); oe_i |= o; end
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) begin
        sbit(wd[24 - 8*k + i], r, o);
        rd[24 - 8*k + i] = r;
        oe_d &= o;
      end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic model_write(input logic [7:0] ins, input logic [31:0] wd);
    logic [4:0] a = ins[4:0];
    for (int k = 0; k <= int'(ins[6:5]); k++) begin
      mdl[a] = wd[24 - 8*k +: 8];
      a = a - 5'd1;
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] ins);
    logic [4:0] a = ins[4:0];
    logic [31:0] v = '0;
    for (int k = 0; k <= int'(ins[6:5]); k++) begin
      v[24 - 8*k +: 8] = mdl[a];
      a = a - 5'd1;
    end
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic oe_i, oe_d, r, o;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 regs after reset", {31'd0, |regs_flat}, 32'd0);
    chk("R1 sdo after reset", {31'd0, sdo}, 32'd0);
    chk("R1 sdio_oe after reset", {31'd0, sdio_oe}, 32'd0);

    // R2 R3 R4 R6 R7 R8: table of bursts, each read back in the other wire mode
    for (int v = 0; v < 8; v++) begin
      logic [7:0] ins = VEC[v][39:32];
      int nb = int'(ins[6:5]) + 1;
      xfer(VEC[v][40], ins, nb, VEC[v][31:0], rd, oe_i, oe_d);
      chk("R7 oe low in instruction", {31'd0, oe_i}, 32'd0);
      if (ins[7]) begin
        chk("R6 R4 R2 read burst data", rd, model_read(ins));
        chk(VEC[v][40] ? "R7 oe high in 3-wire read" : "R8 oe low in 4-wire read",
            {31'd0, oe_d}, {31'd0, VEC[v][40]});
      end else begin
        model_write(ins, VEC[v][31:0]);
        chk("R7 oe low in write", {31'd0, oe_d}, 32'd0);
      end
      chk("R7 oe low after cs_n rises", {31'd0, sdio_oe}, 32'd0);
    end
    for (int i = 0; i < 32; i++) chk("R11 parallel image", {24'd0, regs_flat[8*i +: 8]}, {24'd0, mdl[i]});

    // R9: abort in the data byte, then in the instruction byte
    three_wire = 1'b1; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) sbit(i >= 2 ? 1'b0 : 1'b1, r, o);
    for (int i = 0; i < 4; i++) sbit(1'b1, r, o);
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (8) @(negedge clk);
    chk("R9 partial byte discarded", {24'd0, regs_flat[3*8 +: 8]}, {24'd0, mdl[3]});
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) sbit(1'b1, r, o);
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (8) @(negedge clk);
    xfer(1'b1, 8'h03, 1, 32'h5A000000, rd, oe_i, oe_d);
    model_write(8'h03, 32'h5A000000);
    chk("R9 fresh instruction after abort", {24'd0, regs_flat[3*8 +: 8]}, 32'h5A);
    chk("R9 no stray write to reg 31", {24'd0, regs_flat[31*8 +: 8]}, {24'd0, mdl[31]});

    // R10: single-byte write with an extra byte clocked
    xfer(1'b0, 8'h0A, 2, 32'h99770000, rd, oe_i, oe_d);
    model_write(8'h0A, 32'h99770000);
    chk("R10 addressed register", {24'd0, regs_flat[10*8 +: 8]}, 32'h99);
    chk("R10 extra byte ignored", {24'd0, regs_flat[9*8 +: 8]}, {24'd0, mdl[9]});

    // R5: three-byte write from address 1 wraps to 31
    xfer(1'b1, 8'h41, 3, 32'h12345600, rd, oe_i, oe_d);
    model_write(8'h41, 32'h12345600);
    chk("R5 reg 1", {24'd0, regs_flat[1*8 +: 8]}, 32'h12);
    chk("R5 reg 0", {24'd0, regs_flat[0 +: 8]}, 32'h34);
    chk("R5 wrap to reg 31", {24'd0, regs_flat[31*8 +: 8]}, 32'h56);
    xfer(1'b0, 8'hC0, 3, 32'h0, rd, oe_i, oe_d);
    chk("R5 R8 wrap read in 4-wire", rd, 32'h34566000 >> 4 << 4 & 32'h34560000 | {8'h00, 8'h00, 8'h00, 8'h00} | ({24'd0, mdl[30]} << 8));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule